// File: doc/BRIEF.md
# Run-Time Programmable AND-OR Logic Array

This block evaluates a set of two-level logic functions over a group of data inputs. The functions come from a configuration held in registers and loaded at run time. The array has `N_IN` data inputs, `N_TERM` product terms and `N_OUT` outputs. Each product term is an AND of literals. For every data input and every term, a two-bit code picks the true literal, the complemented literal, or no literal, or it forces the term to zero. Each output is the OR of the product terms its connection bits select. An output can then be inverted, which turns an AND-OR function into an AND-OR-invert function.

Software fills the array through a synchronous write port. Word index `k` for `0 <= k < N_TERM` holds the literal codes and output connections of product term `k`. Index `N_TERM` holds the inversion bits for all outputs. The path from data inputs to outputs is purely combinational from the stored configuration. Once a table is loaded, the block acts as a fixed combinational circuit until it is rewritten or reset.

Top module: `prog_logic_array`

## Requirements
- R1: While `rst_ni` is low, and after it is released, every configuration bit is zero. All outputs then read 0 (no term connected, no inversion) for any value on `data_i`.
- R2: Data input `j` of term `k` takes its literal code from bits `[2j+1:2j]` of the term word. Code 2'b01 uses the input as is, 2'b10 uses its complement and 2'b00 leaves it out. The term is the AND of the literals it uses.
- R3: Code 2'b11 on any input of a term forces that term to 0, whatever the data inputs are.
- R4: A term whose codes are all 2'b00 evaluates to 1.
- R5: Bit `2*N_IN+m` of a term word connects that term to output `m`. Before inversion, output `m` is the OR of its connected terms, and it is 0 when no term is connected.
- R6: Writing index `N_TERM` stores bit `m` of the data word as the inversion flag of output `m`. A flag of 1 inverts the OR result and a flag of 0 passes it unchanged.
- R7: A write takes effect at the rising clock edge where `cfg_we_i` is high. Outputs show the new configuration from that edge onward and not before it. While `cfg_we_i` is low, changes on `cfg_idx_i` and `cfg_data_i` have no effect.
- R8: A write whose index is greater than `N_TERM` changes no configuration.
- R9: With inputs A, B, C on `data_i[2]`, `data_i[1]`, `data_i[0]`, three terms AB', AC and BC produce F1 = AB' + AC on `data_o[0]` and F2 = AC + BC on `data_o[1]`, with neither output inverted.
- R10: Four terms B'C', A'C', A'B' and ABC produce F1 = (B'C' + A'C' + A'B')' on `data_o[0]` with inversion set, and F2 = B'C' + A'C' + ABC on `data_o[1]` without inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for configuration writes |
| rst_ni | input | 1 | Active-low asynchronous reset, clears the configuration |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_idx_i | input | $clog2(N_TERM+1) | Word index: a term number, or N_TERM for the inversion word |
| cfg_data_i | input | 2*N_IN+N_OUT | Write data: literal codes in the low bits, output connections above them |
| data_i | input | N_IN | Data inputs to the logic functions |
| data_o | output | N_OUT | Function outputs |

## Verification
The bench runs the array with three inputs, four terms and two outputs. For each loaded table it sweeps all eight input patterns, so every minterm is compared against a truth table computed in the bench. Single-term tables separate the true, complemented and absent literal codes from one another and from the forcing code. An all-absent term and an unconnected output test the constant-1 term and the constant-0 OR result, and toggling the inversion flags on those constants shows that each output is inverted on its own. The two worked tables combine these pieces: the first uses shared terms with no inversion, and the second inverts one output against the other. Writes are observed just before and just after their clock edge, with the enable low, and with out-of-range indices.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam logic [1:0] LIT_SKIP = 2'b00;
  localparam logic [1:0] LIT_TRUE = 2'b01;
  localparam logic [1:0] LIT_INV  = 2'b10;
  localparam logic [1:0] LIT_KILL = 2'b11;

  function automatic logic lit_eval(input logic [1:0] code, input logic x);
    case (code)
      LIT_TRUE: lit_eval = x;
      LIT_INV:  lit_eval = ~x;
      LIT_SKIP: lit_eval = 1'b1;
      default:  lit_eval = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int N_IN   = 16,
  parameter int N_TERM = 48,
  parameter int N_OUT  = 8,
  localparam int IDX_W = $clog2(N_TERM + 1),
  localparam int CFG_W = 2 * N_IN + N_OUT
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic [IDX_W-1:0]                   idx_i,
  input  logic [CFG_W-1:0]                   data_i,
  output logic [N_TERM-1:0][2*N_IN-1:0]      and_cfg_o,
  output logic [N_TERM-1:0][N_OUT-1:0]       or_cfg_o,
  output logic [N_OUT-1:0]                   inv_o
);
  localparam logic [IDX_W-1:0] INV_IDX = IDX_W'(N_TERM);

  logic [N_TERM-1:0][CFG_W-1:0] term_q;
  logic [N_OUT-1:0]             inv_q;

  for (genvar k = 0; k < N_TERM; k++) begin : g_term
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               term_q[k] <= '0;
      else if (we_i && idx_i == IDX_W'(k))       term_q[k] <= data_i;
    end
    assign and_cfg_o[k] = term_q[k][2*N_IN-1:0];
    assign or_cfg_o[k]  = term_q[k][2*N_IN +: N_OUT];

    // R7: an accepted write lands in its own term word
    assert_write_lands_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && idx_i == IDX_W'(k)) |=> term_q[k] == $past(data_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        inv_q <= '0;
    else if (we_i && idx_i == INV_IDX)  inv_q <= data_i[N_OUT-1:0];
  end
  assign inv_o = inv_q;

  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(term_q) && $stable(inv_q)));

  assert_bad_index_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx_i > INV_IDX) |=> ($stable(term_q) && $stable(inv_q)));
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int N_IN   = 16,
  parameter int N_TERM = 48
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_IN-1:0]               data_i,
  input  logic [N_TERM-1:0][2*N_IN-1:0] and_cfg_i,
  output logic [N_TERM-1:0]             term_o
);
  for (genvar k = 0; k < N_TERM; k++) begin : g_term
    logic [N_IN-1:0] lit;
    logic            killed;
    logic            all_skip;
    for (genvar j = 0; j < N_IN; j++) begin : g_in
      assign lit[j] = lit_eval(and_cfg_i[k][2*j +: 2], data_i[j]);
    end
    assign term_o[k] = &lit;

    // Observers for the checks, derived from the codes only
    always_comb begin
      killed   = 1'b0;
      all_skip = 1'b1;
      for (int j = 0; j < N_IN; j++) begin
        if (and_cfg_i[k][2*j +: 2] == LIT_KILL) killed = 1'b1;
        if (and_cfg_i[k][2*j +: 2] != LIT_SKIP) all_skip = 1'b0;
      end
    end

    assert_kill_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      killed |-> !term_o[k]);
    assert_empty_term_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      all_skip |-> term_o[k]);
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 48,
  parameter int N_OUT  = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_TERM-1:0]            term_i,
  input  logic [N_TERM-1:0][N_OUT-1:0] or_cfg_i,
  input  logic [N_OUT-1:0]             inv_i,
  output logic [N_OUT-1:0]             data_o
);
  for (genvar m = 0; m < N_OUT; m++) begin : g_out
    logic [N_TERM-1:0] col;
    for (genvar k = 0; k < N_TERM; k++) begin : g_col
      assign col[k] = or_cfg_i[k][m];
    end
    assign data_o[m] = (|(col & term_i)) ^ inv_i[m];

    assert_empty_row_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (col == '0) |-> data_o[m] == inv_i[m]);
    assert_polarity_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((col & term_i) != '0) |-> data_o[m] == !inv_i[m]);
  end
endmodule

// File: rtl/prog_logic_array.sv
module prog_logic_array #(
  parameter int N_IN   = 16,
  parameter int N_TERM = 48,
  parameter int N_OUT  = 8,
  localparam int IDX_W = $clog2(N_TERM + 1),
  localparam int CFG_W = 2 * N_IN + N_OUT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [CFG_W-1:0] cfg_data_i,
  input  logic [N_IN-1:0]  data_i,
  output logic [N_OUT-1:0] data_o
);
  logic [N_TERM-1:0][2*N_IN-1:0] and_cfg;
  logic [N_TERM-1:0][N_OUT-1:0]  or_cfg;
  logic [N_OUT-1:0]              inv;
  logic [N_TERM-1:0]             term;

  pla_cfg_store #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) cfg_i (
    .clk_i, .rst_ni,
    .we_i     (cfg_we_i),
    .idx_i    (cfg_idx_i),
    .data_i   (cfg_data_i),
    .and_cfg_o(and_cfg),
    .or_cfg_o (or_cfg),
    .inv_o    (inv)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) and_i (
    .clk_i, .rst_ni,
    .data_i   (data_i),
    .and_cfg_i(and_cfg),
    .term_o   (term)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) or_i (
    .clk_i, .rst_ni,
    .term_i  (term),
    .or_cfg_i(or_cfg),
    .inv_i   (inv),
    .data_o  (data_o)
  );

  // R1: a cleared array drives all outputs low
  assert_cleared_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (or_cfg == '0 && inv == '0) |-> data_o == '0);
endmodule

// File: tb/prog_logic_array_tb_top.sv
module prog_logic_array_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 3, NT = 4, NO = 2;
  localparam int IW = $clog2(NT + 1);
  localparam int CW = 2 * NI + NO;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [IW-1:0] idx = '0;
  logic [CW-1:0] wdata = '0;
  logic [NI-1:0] din = '0;
  logic [NO-1:0] dout;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  localparam logic [1:0] S = 2'b00, T = 2'b01, C = 2'b10, Z = 2'b11;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_logic_array #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_idx_i(idx),
    .cfg_data_i(wdata), .data_i(din), .data_o(dout)
  );

  function automatic logic [CW-1:0] tw(logic [NO-1:0] conn, logic [1:0] ca,
                                       logic [1:0] cb, logic [1:0] cc);
    return {conn, ca, cb, cc};
  endfunction

  task automatic check(string req, logic [NO-1:0] exp);
    checks++;
    if (dout !== exp) begin
      errors++;
      $display("FAIL %s: din=%b data_o=%b expected=%b", req, din, dout, exp);
    end
  endtask

  task automatic wr(int i, logic [CW-1:0] d);
    @(negedge clk);
    we = 1'b1; idx = IW'(i); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic sweep(string req, logic [NO-1:0] exp [8]);
    for (int p = 0; p < 8; p++) begin
      din = NI'(p);
      #1;
      check(req, exp[p]);
    end
  endtask

  task automatic test_reset_r1();
    logic [NO-1:0] e [8];
    for (int p = 0; p < 8; p++) e[p] = '0;
    din = 3'b101; #1; check("R1", 2'b00);   // in reset
    do_reset();
    sweep("R1", e);
  endtask

  task automatic test_literals_r2();
    logic [NO-1:0] e [8];
    do_reset();
    wr(0, tw(2'b01, T, C, S));              // A & ~B
    for (int p = 0; p < 8; p++) e[p] = {1'b0, p[2] & ~p[1]};
    sweep("R2", e);
    wr(1, tw(2'b10, C, S, T));              // ~A & C on output 1
    for (int p = 0; p < 8; p++) e[p] = {~p[2] & p[0], p[2] & ~p[1]};
    sweep("R2", e);
  endtask

  task automatic test_kill_r3();
    logic [NO-1:0] e [8];
    do_reset();
    wr(0, tw(2'b11, S, S, Z));
    wr(1, tw(2'b01, Z, T, S));
    for (int p = 0; p < 8; p++) e[p] = 2'b00;
    sweep("R3", e);
  endtask

  task automatic test_empty_r4_r5_r6();
    logic [NO-1:0] e [8];
    do_reset();
    wr(0, tw(2'b01, S, S, S));              // constant 1 to output 0
    for (int p = 0; p < 8; p++) e[p] = 2'b01;
    sweep("R4", e);                          // output 1 unconnected: R5
    wr(NT, CW'(2'b11));
    for (int p = 0; p < 8; p++) e[p] = 2'b10;
    sweep("R6", e);
    wr(NT, CW'(2'b10));
    for (int p = 0; p < 8; p++) e[p] = 2'b11;
    sweep("R5", e);
  endtask

  task automatic test_timing_r7_r8();
    do_reset();
    din = 3'b000; #1; check("R7", 2'b00);
    @(negedge clk);
    we = 1'b1; idx = IW'(0); wdata = tw(2'b11, S, S, S);
    #1; check("R7", 2'b00);                  // before the edge
    @(negedge clk);
    we = 1'b0; #1; check("R7", 2'b11);      // after the edge
    idx = IW'(NT); wdata = '1;
    repeat (2) @(negedge clk);
    #1; check("R7", 2'b11);                 // enable low: no effect
    wr(NT + 1, '1);
    #1; check("R8", 2'b11);
    wr(7, '1);
    #1; check("R8", 2'b11);
  endtask

  task automatic test_example1_r9();
    logic [NO-1:0] e [8];
    do_reset();
    wr(0, tw(2'b01, T, C, S));
    wr(1, tw(2'b11, T, S, T));
    wr(2, tw(2'b10, S, T, T));
    wr(NT, '0);
    for (int p = 0; p < 8; p++)
      e[p] = {(p[2] & p[0]) | (p[1] & p[0]), (p[2] & ~p[1]) | (p[2] & p[0])};
    sweep("R9", e);
  endtask

  task automatic test_example2_r10();
    logic [NO-1:0] e [8];
    do_reset();
    wr(0, tw(2'b11, S, C, C));
    wr(1, tw(2'b11, C, S, C));
    wr(2, tw(2'b01, C, C, S));
    wr(3, tw(2'b10, T, T, T));
    wr(NT, CW'(2'b01));
    for (int p = 0; p < 8; p++) begin
      logic f1, f2;
      f1 = (p == 3) || (p == 5) || (p == 6) || (p == 7);
      f2 = (p == 0) || (p == 2) || (p == 4) || (p == 7);
      e[p] = {f2, f1};
    end
    sweep("R10", e);
  endtask

  initial begin
    test_reset_r1();
    test_literals_r2();
    test_kill_r3();
    test_empty_r4_r5_r6();
    test_timing_r7_r8();
    test_example1_r9();
    test_example2_r10();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: data_o=%b expected=completion", dout);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule